// File: doc/BRIEF.md
# UART Address Match Receive Filter

This block sits between a UART receiver's deserialiser and its receive buffer and decides, character by character, whether a received character may be written into the buffer. It supports multidrop buses. The most significant bit of each character is the bit just before the stop bit, and it is used as a mark. A marked character is an address. An unmarked character is data belonging to the most recent address.

Address characters are compared over the full character width, mark bit included, against two programmable match values. Each match value has its own enable. A matching address is written to the buffer. A one-bit match state remembers whether the most recent address matched, and data characters pass only while that state is set. Filtering is in force only when at least one enable is set and the match-configuration field is zero. In every other setting the block is transparent and the match state is left alone.

Accepted characters appear on the buffer-write side one clock after the input strobe, together with a single-cycle data-ready set pulse.

Top module: `uart_addr_filter`

## Requirements
- R1: With both match enables at 0, every received character is written to the buffer unchanged, whatever its mark bit.
- R2: With the match-configuration field not equal to 2'b00, the block is transparent even when match enables are set.
- R3: Bit CHAR_W-1 of the character is the mark: 1 means address, 0 means data. A data character is never compared, even if its value equals a match value.
- R4: While filtering, an address character is written only if it equals, over all CHAR_W bits, a match value whose enable is set. Enable bit 0 guards match value 1 and enable bit 1 guards match value 2.
- R5: A match value whose enable bit is 0 never causes a match, even if it equals the received address.
- R6: While filtering, a data character is written only if the most recent address matched. After a non-matching address, all data is discarded until a matching address arrives. A data character that immediately follows an address on the next clock is judged by that address.
- R7: Reset clears the match state and the outputs, so data received while filtering before any address is discarded.
- R8: The buffer-write strobe and the ready-set pulse rise together exactly one clock after an accepted character's valid strobe, last one cycle, and carry that character on the data output. No strobe occurs without a valid input.
- R9: Characters received while the block is transparent do not change the match state. It resumes unchanged when filtering is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | Received-character strobe, one cycle per character |
| rx_char_i | input | CHAR_W | Received character; MSB is the address mark |
| match_en_i | input | 2 | Enables for match value 1 (bit 0) and match value 2 (bit 1) |
| match_val1_i | input | CHAR_W | First match value |
| match_val2_i | input | CHAR_W | Second match value |
| match_cfg_i | input | 2 | Match configuration; filtering only when 2'b00 |
| buf_wr_o | output | 1 | Receive buffer write strobe |
| buf_data_o | output | CHAR_W | Character to write into the buffer |
| ready_set_o | output | 1 | Pulse that sets the data-ready flag |

## Verification
The assertions check several properties on every cycle. A strobe never appears without a preceding valid. Transparent mode passes the character through with one clock of delay. A non-matching address or a data character arriving with the match state clear never produces a write. The match state moves only on a filtered address. Reset leaves the state clear. The bench's scenarios are needed for the behaviour that depends on history and values. This covers data that follows a matched or rejected address, a disabled slot holding an equal value, an unmarked character equal to a match value, back-to-back address and data, and state carried through a transparent period.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    // Classification of one received character
    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_ADDR = 1'b1
    } char_kind_e;

    typedef struct packed {
        char_kind_e kind;
        logic [1:0] slot_hit;   // per-slot comparison result, already gated by enables
    } char_class_t;

    localparam int unsigned NUM_SLOTS = 2;
    localparam logic [1:0]  CFG_ADDR_MATCH = 2'b00;

    // Filtering is in force only for the address-match configuration with a slot enabled
    function automatic logic filter_active(input logic [1:0] en, input logic [1:0] cfg);
        return (|en) && (cfg == CFG_ADDR_MATCH);
    endfunction

endpackage

// File: rtl/uaf_classify.sv
module uaf_classify
    import uaf_pkg::*;
#(
    parameter int unsigned CHAR_W = 9
) (
    input  logic [CHAR_W-1:0] char_i,
    input  logic [1:0]        en_i,
    input  logic [CHAR_W-1:0] val1_i,
    input  logic [CHAR_W-1:0] val2_i,
    output char_class_t       cls_o
);
    localparam int unsigned MARK_POS = CHAR_W - 1;

    logic [CHAR_W-1:0] slot_val [NUM_SLOTS];
    logic [1:0]        hit;

    assign slot_val[0] = val1_i;
    assign slot_val[1] = val2_i;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign hit[s] = en_i[s] && (char_i == slot_val[s]);
    end

    always_comb begin
        cls_o.kind     = char_i[MARK_POS] ? KIND_ADDR : KIND_DATA;
        cls_o.slot_hit = hit;
    end

    // R5: a disabled slot contributes no hit
    always_comb begin
        a_slot_gate_r5: assert (!(cls_o.slot_hit[0] && !en_i[0]) && !(cls_o.slot_hit[1] && !en_i[1]));
    end

endmodule

// File: rtl/uaf_track.sv
module uaf_track (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,     // a filtered address character arrived
    input  logic hit_i,     // that address matched an enabled slot
    output logic matched_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            matched_o <= 1'b0;
        end else if (upd_i) begin
            matched_o <= hit_i;
        end
    end

    // R9: state only moves on a filtered address
    p_hold_state_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(upd_i) |-> $stable(matched_o));

    // R6: state follows the last address outcome
    p_follow_addr_r6: assert property (@(posedge clk) disable iff (rst)
        $past(upd_i) |-> (matched_o == $past(hit_i)));

    // R7: reset leaves the state clear
    p_reset_clear_r7: assert property (@(posedge clk)
        $past(rst) |-> !matched_o);

endmodule

// File: rtl/uaf_emit.sv
module uaf_emit #(
    parameter int unsigned CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [CHAR_W-1:0] char_i,
    output logic              wr_o,
    output logic              ready_o,
    output logic [CHAR_W-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_o    <= 1'b0;
            ready_o <= 1'b0;
            data_o  <= '0;
        end else begin
            wr_o    <= take_i;
            ready_o <= take_i;
            if (take_i) begin
                data_o <= char_i;
            end
        end
    end

    // R8: strobe lasts one cycle per accepted character and carries it
    p_strobe_data_r8: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> (data_o == $past(char_i)));

endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
    import uaf_pkg::*;
#(
    parameter int unsigned CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [CHAR_W-1:0] rx_char_i,
    input  logic [1:0]        match_en_i,
    input  logic [CHAR_W-1:0] match_val1_i,
    input  logic [CHAR_W-1:0] match_val2_i,
    input  logic [1:0]        match_cfg_i,
    output logic              buf_wr_o,
    output logic [CHAR_W-1:0] buf_data_o,
    output logic              ready_set_o
);
    char_class_t cls;
    logic        active;
    logic        addr_hit;
    logic        matched;
    logic        addr_upd;
    logic        take;

    uaf_classify #(.CHAR_W(CHAR_W)) u_classify (
        .char_i (rx_char_i),
        .en_i   (match_en_i),
        .val1_i (match_val1_i),
        .val2_i (match_val2_i),
        .cls_o  (cls)
    );

    assign active   = filter_active(match_en_i, match_cfg_i);
    assign addr_hit = |cls.slot_hit;
    assign addr_upd = rx_valid_i && active && (cls.kind == KIND_ADDR);

    uaf_track u_track (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (addr_upd),
        .hit_i     (addr_hit),
        .matched_o (matched)
    );

    always_comb begin
        if (!rx_valid_i) begin
            take = 1'b0;
        end else if (!active) begin
            take = 1'b1;
        end else if (cls.kind == KIND_ADDR) begin
            take = addr_hit;
        end else begin
            take = matched;
        end
    end

    uaf_emit #(.CHAR_W(CHAR_W)) u_emit (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .char_i  (rx_char_i),
        .wr_o    (buf_wr_o),
        .ready_o (ready_set_o),
        .data_o  (buf_data_o)
    );

    // R8: no strobe without a valid one cycle earlier; ready pulse tracks the write
    p_no_spurious_wr_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_valid_i) |-> (!buf_wr_o && !ready_set_o));
    p_ready_with_wr_r8: assert property (@(posedge clk) disable iff (rst)
        ready_set_o == buf_wr_o);

    // R1 / R2: transparent mode passes every character through
    p_transparent_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rx_valid_i && !active) |-> (buf_wr_o && buf_data_o == $past(rx_char_i)));

    // R4: a non-matching filtered address is never written
    p_addr_reject_r4: assert property (@(posedge clk) disable iff (rst)
        $past(addr_upd && !addr_hit) |-> !buf_wr_o);

    // R6: data with a clear match state is never written
    p_data_drop_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rx_valid_i && active && cls.kind == KIND_DATA && !matched) |-> !buf_wr_o);

endmodule

// File: tb/uart_addr_filter_bench.sv
module uart_addr_filter_bench;
    localparam int unsigned CW = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          rx_valid_i;
    logic [CW-1:0] rx_char_i;
    logic [1:0]    match_en_i;
    logic [CW-1:0] match_val1_i;
    logic [CW-1:0] match_val2_i;
    logic [1:0]    match_cfg_i;
    logic          buf_wr_o;
    logic [CW-1:0] buf_data_o;
    logic          ready_set_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_addr_filter #(.CHAR_W(CW)) u_uart_addr_filter (
        .clk          (clk),
        .rst          (rst),
        .rx_valid_i   (rx_valid_i),
        .rx_char_i    (rx_char_i),
        .match_en_i   (match_en_i),
        .match_val1_i (match_val1_i),
        .match_val2_i (match_val2_i),
        .match_cfg_i  (match_cfg_i),
        .buf_wr_o     (buf_wr_o),
        .buf_data_o   (buf_data_o),
        .ready_set_o  (ready_set_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Check outputs one clock after a strobe
    task automatic expect_out(input bit wr, input logic [CW-1:0] ch, input string req);
        check(buf_wr_o == wr, req, int'(buf_wr_o), int'(wr));
        check(ready_set_o == wr, req, int'(ready_set_o), int'(wr));
        if (wr) check(buf_data_o == ch, req, int'(buf_data_o), int'(ch));
    endtask

    task automatic send(input logic [CW-1:0] ch, input bit wr, input string req);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_char_i  = ch;
        @(negedge clk);
        rx_valid_i = 1'b0;
        expect_out(wr, ch, req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        rx_valid_i = 1'b0;
        rx_char_i = '0;
        match_en_i = 2'b00;
        match_cfg_i = 2'b00;
        match_val1_i = 9'h112;
        match_val2_i = 9'h1F0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out(1'b0, '0, "R7 reset");
    endtask

    task automatic t_data_before_addr();
        match_en_i = 2'b01;
        send(9'h055, 1'b0, "R7 data before any address");
    endtask

    task automatic t_slot1();
        match_en_i = 2'b01;
        send(9'h112, 1'b1, "R4 matching address");
        send(9'h077, 1'b1, "R6 data after match");
        send(9'h113, 1'b0, "R4 non-matching address");
        send(9'h078, 1'b0, "R6 data after miss");
        send(9'h112 & 9'h0FF, 1'b0, "R3 unmarked equal value is data");
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_char_i  = 9'h112;
        @(negedge clk);
        rx_char_i  = 9'h0A1;
        expect_out(1'b1, 9'h112, "R6 b2b address");
        @(negedge clk);
        rx_valid_i = 1'b0;
        expect_out(1'b1, 9'h0A1, "R6 b2b data");
        @(negedge clk);
        expect_out(1'b0, '0, "R8 single-cycle strobe");
    endtask

    task automatic t_slot2();
        match_en_i = 2'b10;
        send(9'h112, 1'b0, "R5 disabled slot equal value");
        send(9'h0AB, 1'b0, "R6 data after disabled-slot address");
        send(9'h1F0, 1'b1, "R4 slot2 match");
        send(9'h0AC, 1'b1, "R6 data after slot2 match");
    endtask

    task automatic t_transparent();
        match_en_i = 2'b00;
        send(9'h041, 1'b1, "R1 data transparent");
        send(9'h1A5, 1'b1, "R1 address transparent");
        match_en_i = 2'b11;
        match_cfg_i = 2'b01;
        send(9'h033, 1'b1, "R2 cfg nonzero data");
        send(9'h1CC, 1'b1, "R2 cfg nonzero address");
        match_cfg_i = 2'b00;
    endtask

    task automatic t_hold();
        // state currently matched (slot2); transparent chars must not clear it
        match_en_i = 2'b10;
        send(9'h1F0, 1'b1, "R9 set state");
        match_en_i = 2'b00;
        send(9'h1AA, 1'b1, "R9 transparent address");
        match_en_i = 2'b10;
        send(9'h022, 1'b1, "R9 state kept matched");
        send(9'h1AA, 1'b0, "R4 miss clears state");
        match_en_i = 2'b00;
        send(9'h1F0, 1'b1, "R9 transparent match value");
        match_en_i = 2'b10;
        send(9'h045, 1'b0, "R9 state kept cleared");
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            expect_out(1'b0, '0, "R8 no strobe when idle");
        end
    endtask

    initial begin
        t_reset();
        t_data_before_addr();
        t_slot1();
        t_back_to_back();
        t_slot2();
        t_transparent();
        t_hold();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule